// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block compares two single-precision IEEE-754 operands and registers the outcome as processor-style condition flags. The four-way result (unordered, greater, less, equal) is encoded onto the zero, parity and carry flags. The overflow, sign and auxiliary flags are cleared on every compare that commits. A request is a one-cycle `cmp_valid` pulse carrying both operands, a mode bit and two exception mask bits. The flags and a `res_valid` strobe appear one clock later.

The mode bit picks how NaN operands are treated. In quiet mode, only a signalling NaN raises the invalid exception. In signalling mode, any NaN raises it. A denormal operand raises the denormal exception. Both exception bits are sticky, and they stay set until `stat_clear` is asserted. If a compare raises an exception whose mask bit is 0, the flag register keeps its previous value. The exception status is still recorded in that case.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), a committed compare sets {zf,pf,cf} = 3'b111.
- R2: For ordered, unequal operands, a committed compare sets {zf,pf,cf} = 3'b000 when op_a > op_b and 3'b001 when op_a < op_b. Values are ordered by sign and magnitude, and the order is reversed when both operands are negative. Infinities are the extreme values and denormals keep their value.
- R3: Equal operands set {zf,pf,cf} = 3'b100. Positive zero and negative zero count as equal.
- R4: The flags of, sf and af are 0 after every committed compare and after reset.
- R5: With cmp_signal = 0, stat_invalid is raised only by a signalling NaN, which is a NaN with fraction bit 22 = 0. A quiet NaN has fraction bit 22 = 1 and does not raise it.
- R6: With cmp_signal = 1, any NaN operand raises stat_invalid.
- R7: An operand with exponent 0 and a nonzero fraction raises stat_denorm.
- R8: If a compare raises invalid with mask_invalid = 0, or raises denormal with mask_denorm = 0, then zf, pf, cf, of, sf and af keep their previous values.
- R9: res_valid is high exactly one cycle after a cmp_valid pulse. The flags change only on the edge that follows a cmp_valid.
- R10: stat_invalid and stat_denorm stay set until stat_clear is asserted. A clear empties both bits. An exception raised in the same cycle as the clear is still recorded.
- R11: Reset makes all flags, both status bits and res_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare request strobe |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| cmp_signal | input | 1 | 1 selects signalling compare, 0 selects quiet compare |
| mask_invalid | input | 1 | 1 masks the invalid exception |
| mask_denorm | input | 1 | 1 masks the denormal exception |
| stat_clear | input | 1 | Clears the sticky exception status |
| res_valid | output | 1 | Result strobe, one cycle after cmp_valid |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| af | output | 1 | Auxiliary flag |
| stat_invalid | output | 1 | Sticky invalid exception status |
| stat_denorm | output | 1 | Sticky denormal exception status |

## Verification
The bench targets several corner cases:
- Two negative operands, where a design that reuses the positive magnitude order returns the wrong one of greater and less.
- Zeros of opposite sign, which a bitwise-equality design reports as unequal.
- Quiet NaNs in quiet mode, which a design confusing fraction bit 22 polarity would flag as invalid.
- Quiet NaNs in signalling mode, which are missed if the mode bit is ignored.

It also checks the following:
- Unmasked exceptions, where a design that commits anyway overwrites the held flags.
- A status clear in the same cycle as a new exception, where a clear-wins design loses the event.
- Denormals and infinities against normal values, checked under random masks and modes.

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_valid,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic                    cmp_signal,
  input  logic                    mask_invalid,
  input  logic                    mask_denorm,
  input  logic                    stat_clear,
  output logic                    res_valid,
  output logic                    zf,
  output logic                    pf,
  output logic                    cf,
  output logic                    of,
  output logic                    sf,
  output logic                    af,
  output logic                    stat_invalid,
  output logic                    stat_denorm
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [FRAC_W-1:0] frac_a, frac_b;
  logic [W-2:0]      mag_a, mag_b;
  logic              sgn_a, sgn_b;

  assign {sgn_a, exp_a, frac_a} = op_a;
  assign {sgn_b, exp_b, frac_b} = op_b;
  assign mag_a = op_a[W-2:0];
  assign mag_b = op_b[W-2:0];

  logic a_nan, b_nan, a_snan, b_snan, a_den, b_den;
  assign a_nan  = (&exp_a) && (|frac_a);
  assign b_nan  = (&exp_b) && (|frac_b);
  assign a_snan = a_nan && !frac_a[FRAC_W-1];
  assign b_snan = b_nan && !frac_b[FRAC_W-1];
  assign a_den  = !(|exp_a) && (|frac_a);
  assign b_den  = !(|exp_b) && (|frac_b);

  logic any_nan, any_snan, any_den;
  assign any_nan  = a_nan  || b_nan;
  assign any_snan = a_snan || b_snan;
  assign any_den  = a_den  || b_den;

  logic both_zero, is_eq, a_gt;
  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign is_eq     = both_zero || (op_a == op_b);
  assign a_gt      = (sgn_a != sgn_b) ? !sgn_a
                   : (sgn_a ? (mag_a < mag_b) : (mag_a > mag_b));

  logic [2:0] code;
  always_comb begin
    if (any_nan)    code = 3'b111;
    else if (is_eq) code = 3'b100;
    else if (a_gt)  code = 3'b000;
    else            code = 3'b001;
  end

  logic inv_evt, den_evt, blocked;
  assign inv_evt = cmp_signal ? any_nan : any_snan;
  assign den_evt = any_den;
  assign blocked = (inv_evt && !mask_invalid) || (den_evt && !mask_denorm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      {zf, pf, cf} <= 3'b000;
      {of, sf, af} <= 3'b000;
      stat_invalid <= 1'b0;
      stat_denorm  <= 1'b0;
    end else begin
      res_valid <= cmp_valid;
      if (cmp_valid && !blocked) begin
        {zf, pf, cf} <= code;
        {of, sf, af} <= 3'b000;
      end
      stat_invalid <= (stat_invalid && !stat_clear) || (cmp_valid && inv_evt);
      stat_denorm  <= (stat_denorm  && !stat_clear) || (cmp_valid && den_evt);
    end
  end

  p_nan_unord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && any_nan && mask_invalid && mask_denorm |=> {zf, pf, cf} == 3'b111);
  p_flag_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ({zf, pf, cf} inside {3'b111, 3'b000, 3'b001, 3'b100}));
  p_zero_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && both_zero && !any_den |=> {zf, pf, cf} == 3'b100);
  p_no_osa_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(of || sf || af));
  p_quiet_qnan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_signal && !any_snan && !stat_invalid |=> !stat_invalid);
  p_sig_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_signal && any_nan |=> stat_invalid);
  p_denorm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && any_den |=> stat_denorm);
  p_hold_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && any_snan && !mask_invalid |=> $stable({zf, pf, cf}));
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid && $stable({zf, pf, cf}));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_invalid && !stat_clear |=> stat_invalid);
endmodule

// File: tb/fcmp_flag_unit_tb_top.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0, cmp_signal = 1'b0, mask_invalid = 1'b1, mask_denorm = 1'b1, stat_clear = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic res_valid, zf, pf, cf, of, sf, af, stat_invalid, stat_denorm;

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] m_flags = 3'b000;
  logic m_inv = 1'b0, m_den = 1'b0;

  always #2.5 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
    .cmp_signal(cmp_signal), .mask_invalid(mask_invalid), .mask_denorm(mask_denorm),
    .stat_clear(stat_clear), .res_valid(res_valid), .zf(zf), .pf(pf), .cf(cf),
    .of(of), .sf(sf), .af(af), .stat_invalid(stat_invalid), .stat_denorm(stat_denorm)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [31:0] v);
    return is_nan(v) && (v[22] == 1'b0);
  endfunction
  function automatic bit is_den(input logic [31:0] v);
    return (v[30:23] == 8'h00) && (v[22:0] != 0);
  endfunction
  function automatic longint okey(input logic [31:0] v);
    longint m;
    m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction
  function automatic logic [2:0] exp_code(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 3'b111;
    if (okey(a) == okey(b)) return 3'b100;
    if (okey(a) > okey(b)) return 3'b000;
    return 3'b001;
  endfunction

  function automatic logic [31:0] mk(input int cls, input bit s);
    logic [31:0] r;
    r = $urandom;
    case (cls)
      0: return {s, 31'h0};
      1: return {s, 8'h00, r[22:0] | 23'h1};
      2: return {s, 8'h7F, r[22:0]};
      3: return {s, 8'hFF, 23'h0};
      4: return {s, 8'hFF, 1'b1, r[21:0]};
      5: return {s, 8'hFF, 1'b0, r[21:0] | 22'h1};
      default: return {s, (r[30:23] % 8'd254) + 8'd1, r[22:0]};
    endcase
  endfunction

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input bit mode,
                        input bit mi, input bit md, input bit clr);
    bit inv, den, blk, nan;
    logic [2:0] code;
    string freq;
    @(negedge clk);
    op_a = a; op_b = b; cmp_signal = mode; mask_invalid = mi; mask_denorm = md;
    stat_clear = clr; cmp_valid = 1'b1;
    nan  = is_nan(a) || is_nan(b);
    inv  = mode ? nan : (is_snan(a) || is_snan(b));
    den  = is_den(a) || is_den(b);
    blk  = (inv && !mi) || (den && !md);
    code = exp_code(a, b);
    if (!blk) m_flags = code;
    m_inv = (m_inv && !clr) || inv;
    m_den = (m_den && !clr) || den;
    freq = blk ? "R8" : nan ? "R1" : (code == 3'b100) ? "R3" : "R2";
    @(negedge clk);
    chk({zf, pf, cf} == m_flags, freq, "zf/pf/cf", {29'h0, zf, pf, cf}, {29'h0, m_flags});
    chk({of, sf, af} == 3'b000, "R4", "of/sf/af", {29'h0, of, sf, af}, 32'h0);
    chk(stat_invalid == m_inv, mode ? (clr ? "R10/R6" : "R6") : (clr ? "R10/R5" : "R5"),
        "stat_invalid", {31'h0, stat_invalid}, {31'h0, m_inv});
    chk(stat_denorm == m_den, clr ? "R10/R7" : "R7", "stat_denorm",
        {31'h0, stat_denorm}, {31'h0, m_den});
    chk(res_valid == 1'b1, "R9", "res_valid", {31'h0, res_valid}, 32'h1);
    cmp_valid = 1'b0; stat_clear = 1'b0;
  endtask

  task automatic idle(input bit clr);
    @(negedge clk);
    stat_clear = clr;
    op_a = 32'h7FC0_0000; op_b = 32'h0000_0001;
    if (clr) begin m_inv = 1'b0; m_den = 1'b0; end
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", "idle res_valid", {31'h0, res_valid}, 32'h0);
    chk({zf, pf, cf} == m_flags, "R9", "idle flags", {29'h0, zf, pf, cf}, {29'h0, m_flags});
    chk({stat_invalid, stat_denorm} == {m_inv, m_den}, "R10", "idle status",
        {30'h0, stat_invalid, stat_denorm}, {30'h0, m_inv, m_den});
    stat_clear = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({res_valid, zf, pf, cf, of, sf, af, stat_invalid, stat_denorm} == 9'h0, "R11",
        "reset state", {23'h0, res_valid, zf, pf, cf, of, sf, af, stat_invalid, stat_denorm}, 32'h0);
    rst_n = 1'b1;
    do_cmp(32'h3F80_0000, 32'h4000_0000, 0, 1, 1, 0); // R2 1.0 < 2.0
    do_cmp(32'hBF80_0000, 32'hC000_0000, 0, 1, 1, 0); // R2 -1 > -2
    do_cmp(32'h0000_0000, 32'h8000_0000, 0, 1, 1, 0); // R3 +0 == -0
    do_cmp(32'h7F80_0000, 32'h7F7F_FFFF, 0, 1, 1, 0); // R2 inf > max
    do_cmp(32'h7FC0_0000, 32'h3F80_0000, 0, 1, 1, 0); // R1/R5 qNaN quiet
    do_cmp(32'h3F80_0000, 32'h7F80_0001, 0, 0, 1, 0); // R8 sNaN unmasked hold
    idle(1);                                          // R10 clear
    do_cmp(32'hFFC0_0000, 32'h0, 1, 1, 1, 0);         // R6 qNaN signalling
    do_cmp(32'h3F80_0000, 32'h3F80_0000, 1, 0, 1, 0); // R3 equal
    do_cmp(32'h7FC0_0000, 32'h0, 1, 0, 1, 1);         // R8/R10 hold, clear + event
    do_cmp(32'h0000_0001, 32'h0, 0, 1, 0, 0);         // R7 denorm unmasked hold
    do_cmp(32'h8000_0001, 32'h0, 0, 1, 1, 1);         // R7/R2 denorm masked
    idle(0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = mk($urandom % 7, 1'($urandom));
      b = ($urandom % 8 == 0) ? a : mk($urandom % 7, 1'($urandom));
      do_cmp(a, b, 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 10) == 0);
      if (i % 97 == 0) idle(1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule